// File: doc/BRIEF.md
# CCD Vertical Line Sequence Generator

This block produces the vertical transfer clocks for one CCD readout line, together with the line-sync pulse and the clamp, pixel-blank and horizontal-blank strobes for that line. It runs on the pixel clock. Each pulse on `line_start_i` begins a line. A pixel counter then walks from zero to the programmed line length and stops. A line flagged as the last one of a field uses its own length setting.

Two pattern groups are available. A group is a short waveform with its own length in pixels, its own start pixel in the line, and, for every vertical output, a start polarity plus two toggle positions. Each vertical output is routed to one of the two groups. The group is played back to back a number of times. That count is taken from one setting on odd lines and from another on even lines. Two hold windows, each with its own enable, freeze the vertical outputs chosen by a mask. The three strobes are each built from a start level and two toggle positions counted on the line's pixel counter.

All configuration is copied into shadow registers when a line starts. A change made while a line is running therefore only takes effect on the next line.

Top module: `vseq_line_gen`

## Requirements
- R1: A pulse on `line_start_i` starts a line of N = `line_len_i`+1 pixels (field holds length minus one, 13 bits, so at most 8192 pixels). The outputs for pixel p are updated at the (p+1)-th rising edge after the edge that samples the pulse. After pixel N-1 every output except `hd_o` keeps its value until the next pulse.
- R2: `hd_o` is high for pixel 0 of a line only, and is low while the block is idle.
- R3: When `last_line_i` is high at the line start, the line length is `last_len_i`+1 instead of `line_len_i`+1.
- R4: Vertical output j follows group `out_sel_i[j]` (0 or 1). Group g's fields sit at the following positions: polarity at bit g*13+j of `grp_pol_i`, and toggle positions at bits [(g*13+j)*13 +: 13] of `grp_tog1_i` and `grp_tog2_i`. While the group is running at local position q, the level is pol ^ (q >= tog1) ^ (q >= tog2). While the group is not running, the level is pol.
- R5: Group g has its own start pixel `grp_start_i[g*13 +: 13]` and its own length `grp_len_i[g*13 +: 13]`+1 pixels. Its local position is 0 at the start pixel.
- R6: A group is played rep+1 times back to back, with local position restarting at 0 right after each instance. rep is `rep_odd_i` when `line_odd_i` is 1 at the line start, and `rep_even_i` otherwise. A group whose start lies beyond the line never runs.
- R7: For each window k with `frz_en_i[k]` set, the vertical outputs whose bit in `hold_mask_i` is 1 keep their previous value for every pixel p with `frz_pos_i[k*13 +: 13]` <= p < `rsm_pos_i[k*13 +: 13]`. Unmasked outputs and disabled windows are unaffected.
- R8: Strobe s (0 clamp, 1 pixel blank, 2 horizontal blank) at pixel p is `stb_pol_i[s]` ^ (p >= `stb_tog1_i[s*13 +: 13]`) ^ (p >= `stb_tog2_i[s*13 +: 13]`).
- R9: Configuration inputs, `line_odd_i` and `last_line_i` are sampled only at the line start. Changes made during a line have no effect on that line.
- R10: After reset, all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Line start strobe |
| line_odd_i | input | 1 | Line parity, 1 = odd |
| last_line_i | input | 1 | Line is the last of the field |
| line_len_i | input | 13 | Normal line length minus one |
| last_len_i | input | 13 | Last-line length minus one |
| grp_len_i | input | 26 | Per-group length minus one |
| grp_start_i | input | 26 | Per-group start pixel |
| grp_pol_i | input | 26 | Per-group, per-output start polarity |
| grp_tog1_i | input | 338 | Per-group, per-output first toggle |
| grp_tog2_i | input | 338 | Per-group, per-output second toggle |
| out_sel_i | input | 13 | Group choice per vertical output |
| rep_odd_i | input | 8 | Extra repeats on odd lines |
| rep_even_i | input | 8 | Extra repeats on even lines |
| frz_pos_i | input | 26 | Hold window start pixels |
| rsm_pos_i | input | 26 | Hold window end pixels (exclusive) |
| frz_en_i | input | 2 | Hold window enables |
| hold_mask_i | input | 13 | Outputs affected by hold windows |
| stb_pol_i | input | 3 | Strobe start levels |
| stb_tog1_i | input | 39 | Strobe first toggles |
| stb_tog2_i | input | 39 | Strobe second toggles |
| vclk_o | output | 13 | Vertical clocks |
| hd_o | output | 1 | Line sync pulse |
| clamp_o | output | 1 | Clamp strobe |
| pblk_o | output | 1 | Pixel blank strobe |
| hblk_o | output | 1 | Horizontal blank strobe |

## Verification
The outputs for pixel p of a line are due at the (p+1)-th rising edge after the edge that samples `line_start_i`. The bench raises the strobe at a falling edge and lowers it one cycle later. It then compares pixel p at the (p+2)-th falling edge after raising the strobe, so every sample lands half a cycle after the register that carries it. Three idle cycles after each line are also compared, to show that the outputs hold and `hd_o` stays low. The configuration is scrambled one cycle after each strobe, so any leak of a mid-line write shows up in those comparisons.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int PIX_W   = 13;  // pixel position width (8192 pixels)
  localparam int NUM_V   = 13;  // vertical clock outputs
  localparam int REP_W   = 8;   // repeat count width
  localparam int NUM_GRP = 2;   // selectable pattern groups
  localparam int NUM_FRZ = 2;   // hold windows
  localparam int NUM_STB = 3;   // clamp, pixel blank, horizontal blank

  typedef enum logic [1:0] {
    STB_CLAMP = 2'd0,
    STB_PBLK  = 2'd1,
    STB_HBLK  = 2'd2
  } stb_idx_e;
endpackage

// File: rtl/vseq_toggle_lvl.sv
module vseq_toggle_lvl #(
  parameter int W = 13
) (
  input  logic         en_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] tog1_i,
  input  logic [W-1:0] tog2_i,
  input  logic         pol_i,
  output logic         lvl_o
);
  // Level starts at pol and flips once at each toggle position reached.
  always_comb begin
    if (en_i) lvl_o = pol_i ^ (pos_i >= tog1_i) ^ (pos_i >= tog2_i);
    else      lvl_o = pol_i;
  end
endmodule

// File: rtl/vseq_hold_win.sv
module vseq_hold_win #(
  parameter int W = 13
) (
  input  logic         en_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_win_o
);
  always_comb in_win_o = en_i && (pos_i >= lo_i) && (pos_i < hi_i);
endmodule

// File: rtl/vseq_grp_engine.sv
module vseq_grp_engine #(
  parameter int PW = 13,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          init_i,     // line start: load settings
  input  logic          adv_i,      // pixel counter advances this cycle
  input  logic [PW-1:0] cnt_nxt_i,  // pixel index after this cycle
  input  logic [PW-1:0] start_i,
  input  logic [PW-1:0] len_m1_i,
  input  logic [RW-1:0] rep_i,
  output logic          run_o,
  output logic [PW-1:0] q_o
);
  logic [PW-1:0] start_s;
  logic [PW-1:0] len_s;
  logic [RW-1:0] rep_left;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      start_s  <= '0;
      len_s    <= '0;
      rep_left <= '0;
      run_o    <= 1'b0;
      q_o      <= '0;
    end else if (init_i) begin
      start_s  <= start_i;
      len_s    <= len_m1_i;
      rep_left <= rep_i;
      q_o      <= '0;
      run_o    <= (start_i == '0);
    end else if (adv_i) begin
      if (run_o) begin
        if (q_o == len_s) begin
          q_o <= '0;
          if (rep_left == '0) run_o <= 1'b0;
          else                rep_left <= rep_left - 1'b1;
        end else begin
          q_o <= q_o + 1'b1;
        end
      end else if (cnt_nxt_i == start_s) begin
        run_o <= 1'b1;
        q_o   <= '0;
      end
    end
  end

  // R6: local position never passes the end of one group instance
  assert_q_bound_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    run_o |-> (q_o <= len_s));

  // R5: a group that is not running restarts from local position zero
  assert_restart_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_o && !init_i && adv_i && cnt_nxt_i == start_s) |=> (run_o && q_o == '0));
endmodule

// File: rtl/vseq_line_gen.sv
module vseq_line_gen
  import vseq_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int NV = NUM_V,
  parameter int RW = REP_W,
  parameter int NG = NUM_GRP,
  parameter int NF = NUM_FRZ,
  parameter int NS = NUM_STB
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               line_start_i,
  input  logic               line_odd_i,
  input  logic               last_line_i,
  input  logic [PW-1:0]      line_len_i,
  input  logic [PW-1:0]      last_len_i,
  input  logic [NG*PW-1:0]   grp_len_i,
  input  logic [NG*PW-1:0]   grp_start_i,
  input  logic [NG*NV-1:0]   grp_pol_i,
  input  logic [NG*NV*PW-1:0] grp_tog1_i,
  input  logic [NG*NV*PW-1:0] grp_tog2_i,
  input  logic [NV-1:0]      out_sel_i,
  input  logic [RW-1:0]      rep_odd_i,
  input  logic [RW-1:0]      rep_even_i,
  input  logic [NF*PW-1:0]   frz_pos_i,
  input  logic [NF*PW-1:0]   rsm_pos_i,
  input  logic [NF-1:0]      frz_en_i,
  input  logic [NV-1:0]      hold_mask_i,
  input  logic [NS-1:0]      stb_pol_i,
  input  logic [NS*PW-1:0]   stb_tog1_i,
  input  logic [NS*PW-1:0]   stb_tog2_i,
  output logic [NV-1:0]      vclk_o,
  output logic               hd_o,
  output logic               clamp_o,
  output logic               pblk_o,
  output logic               hblk_o
);
  localparam int GI = (NG > 1) ? $clog2(NG) : 1;

  // ---------------- shadow copies, loaded at line start (R9)
  logic [PW-1:0]       len_s;
  logic [NG*NV-1:0]    pol_s;
  logic [NG*NV*PW-1:0] t1_s, t2_s;
  logic [NV-1:0]       sel_s, mask_s;
  logic [NF*PW-1:0]    frz_s, rsm_s;
  logic [NF-1:0]       fen_s;
  logic [NS-1:0]       spol_s;
  logic [NS*PW-1:0]    st1_s, st2_s;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      len_s  <= '0;
      pol_s  <= '0;
      t1_s   <= '0;
      t2_s   <= '0;
      sel_s  <= '0;
      mask_s <= '0;
      frz_s  <= '0;
      rsm_s  <= '0;
      fen_s  <= '0;
      spol_s <= '0;
      st1_s  <= '0;
      st2_s  <= '0;
    end else if (line_start_i) begin
      len_s  <= last_line_i ? last_len_i : line_len_i;
      pol_s  <= grp_pol_i;
      t1_s   <= grp_tog1_i;
      t2_s   <= grp_tog2_i;
      sel_s  <= out_sel_i;
      mask_s <= hold_mask_i;
      frz_s  <= frz_pos_i;
      rsm_s  <= rsm_pos_i;
      fen_s  <= frz_en_i;
      spol_s <= stb_pol_i;
      st1_s  <= stb_tog1_i;
      st2_s  <= stb_tog2_i;
    end
  end

  // ---------------- pixel counter
  logic [PW-1:0] cnt;
  logic [PW-1:0] cnt_nxt;
  logic          active;

  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (line_start_i) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == len_s) active <= 1'b0;
      else              cnt    <= cnt_nxt;
    end
  end

  // ---------------- pattern group engines
  logic [RW-1:0]  rep_sel;
  logic [NG-1:0]  grp_run;
  logic [PW-1:0]  grp_q [NG];

  assign rep_sel = line_odd_i ? rep_odd_i : rep_even_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    vseq_grp_engine #(.PW(PW), .RW(RW)) u_eng (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .init_i    (line_start_i),
      .adv_i     (active),
      .cnt_nxt_i (cnt_nxt),
      .start_i   (grp_start_i[g*PW +: PW]),
      .len_m1_i  (grp_len_i[g*PW +: PW]),
      .rep_i     (rep_sel),
      .run_o     (grp_run[g]),
      .q_o       (grp_q[g])
    );
  end

  // ---------------- per-output waveform from the selected group
  logic [NV-1:0] wave;

  for (genvar j = 0; j < NV; j++) begin : g_vout
    logic [GI-1:0] gs;
    assign gs = GI'(sel_s[j]);
    vseq_toggle_lvl #(.W(PW)) u_lvl (
      .en_i   (grp_run[gs]),
      .pos_i  (grp_q[gs]),
      .tog1_i (t1_s[(int'(gs)*NV + j)*PW +: PW]),
      .tog2_i (t2_s[(int'(gs)*NV + j)*PW +: PW]),
      .pol_i  (pol_s[int'(gs)*NV + j]),
      .lvl_o  (wave[j])
    );
  end

  // ---------------- hold windows
  logic [NF-1:0] in_win;
  logic [NV-1:0] held_m;

  for (genvar k = 0; k < NF; k++) begin : g_hold
    vseq_hold_win #(.W(PW)) u_win (
      .en_i     (fen_s[k]),
      .pos_i    (cnt),
      .lo_i     (frz_s[k*PW +: PW]),
      .hi_i     (rsm_s[k*PW +: PW]),
      .in_win_o (in_win[k])
    );
  end

  assign held_m = (|in_win) ? mask_s : '0;

  // ---------------- clamp and blanking strobes
  logic [NS-1:0] stb_lvl;

  for (genvar s = 0; s < NS; s++) begin : g_stb
    vseq_toggle_lvl #(.W(PW)) u_lvl (
      .en_i   (1'b1),
      .pos_i  (cnt),
      .tog1_i (st1_s[s*PW +: PW]),
      .tog2_i (st2_s[s*PW +: PW]),
      .pol_i  (spol_s[s]),
      .lvl_o  (stb_lvl[s])
    );
  end

  // ---------------- registered outputs
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vclk_o  <= '0;
      hd_o    <= 1'b0;
      clamp_o <= 1'b0;
      pblk_o  <= 1'b0;
      hblk_o  <= 1'b0;
    end else if (active) begin
      vclk_o  <= (vclk_o & held_m) | (wave & ~held_m);
      hd_o    <= (cnt == '0);
      clamp_o <= stb_lvl[STB_CLAMP];
      pblk_o  <= stb_lvl[STB_PBLK];
      hblk_o  <= stb_lvl[STB_HBLK];
    end else begin
      hd_o    <= 1'b0;
    end
  end

  // ---------------- assertions
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    active |-> (cnt <= len_s));

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!active && !line_start_i) |=> ($stable(vclk_o) && $stable(clamp_o) && !hd_o));

  assert_hd_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (active && cnt != '0) |=> !hd_o);

  assert_hold_keep_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (active && held_m != '0) |=>
      ((vclk_o & $past(held_m)) == ($past(vclk_o) & $past(held_m))));

  assert_shadow_stable_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !line_start_i |=> ($stable(len_s) && $stable(mask_s) && $stable(t1_s)));

  assert_reset_clear_R10: assert property (@(posedge clk_i)
    rst_i |=> (vclk_o == '0 && !hd_o && !clamp_o && !pblk_o && !hblk_o));
endmodule

// File: tb/vseq_line_gen_tb.sv
module vseq_line_gen_tb;
  localparam int PW = 13;
  localparam int NV = 13;
  localparam int RW = 8;

  typedef struct packed {
    logic [PW-1:0]      line_len;
    logic [PW-1:0]      last_len;
    logic [2*PW-1:0]    g_len;
    logic [2*PW-1:0]    g_start;
    logic [2*NV-1:0]    g_pol;
    logic [2*NV*PW-1:0] g_t1;
    logic [2*NV*PW-1:0] g_t2;
    logic [NV-1:0]      sel;
    logic [NV-1:0]      mask;
    logic [RW-1:0]      rep_odd;
    logic [RW-1:0]      rep_even;
    logic [2*PW-1:0]    f_pos;
    logic [2*PW-1:0]    r_pos;
    logic [1:0]         f_en;
    logic [2:0]         s_pol;
    logic [3*PW-1:0]    s_t1;
    logic [3*PW-1:0]    s_t2;
  } cfg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic line_odd = 1'b0;
  logic last_line = 1'b0;
  cfg_t cur;
  cfg_t snap;

  logic [NV-1:0] vclk;
  logic hd, clamp, pblk, hblk;

  int total = 0;
  int bad = 0;
  logic [NV-1:0] exp_v;

  always #10 clk = ~clk;  // 50 MHz

  vseq_line_gen u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .line_start_i (line_start),
    .line_odd_i   (line_odd),
    .last_line_i  (last_line),
    .line_len_i   (cur.line_len),
    .last_len_i   (cur.last_len),
    .grp_len_i    (cur.g_len),
    .grp_start_i  (cur.g_start),
    .grp_pol_i    (cur.g_pol),
    .grp_tog1_i   (cur.g_t1),
    .grp_tog2_i   (cur.g_t2),
    .out_sel_i    (cur.sel),
    .rep_odd_i    (cur.rep_odd),
    .rep_even_i   (cur.rep_even),
    .frz_pos_i    (cur.f_pos),
    .rsm_pos_i    (cur.r_pos),
    .frz_en_i     (cur.f_en),
    .hold_mask_i  (cur.mask),
    .stb_pol_i    (cur.s_pol),
    .stb_tog1_i   (cur.s_t1),
    .stb_tog2_i   (cur.s_t2),
    .vclk_o       (vclk),
    .hd_o         (hd),
    .clamp_o      (clamp),
    .pblk_o       (pblk),
    .hblk_o       (hblk)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rand_cfg();
    cur.line_len = PW'($urandom_range(63, 8));
    cur.last_len = PW'($urandom_range(63, 4));
    for (int g = 0; g < 2; g++) begin
      cur.g_len[g*PW +: PW]   = PW'($urandom_range(7, 0));
      cur.g_start[g*PW +: PW] = PW'($urandom_range(40, 0));
      for (int j = 0; j < NV; j++) begin
        cur.g_pol[g*NV + j]            = 1'($urandom_range(1, 0));
        cur.g_t1[(g*NV + j)*PW +: PW]  = PW'($urandom_range(9, 0));
        cur.g_t2[(g*NV + j)*PW +: PW]  = PW'($urandom_range(9, 0));
      end
      cur.f_pos[g*PW +: PW] = PW'($urandom_range(50, 0));
      cur.r_pos[g*PW +: PW] = PW'($urandom_range(60, 0));
    end
    cur.sel      = NV'($urandom);
    cur.mask     = NV'($urandom);
    cur.rep_odd  = RW'($urandom_range(4, 0));
    cur.rep_even = RW'($urandom_range(4, 0));
    cur.f_en     = 2'($urandom);
    cur.s_pol    = 3'($urandom);
    for (int s = 0; s < 3; s++) begin
      cur.s_t1[s*PW +: PW] = PW'($urandom_range(70, 0));
      cur.s_t2[s*PW +: PW] = PW'($urandom_range(70, 0));
    end
  endtask

  // Directed base: group 0 starts at 2, length 4; group 1 starts at 9, length 3.
  task automatic base_cfg();
    cur = '0;
    cur.line_len = PW'(29);
    cur.last_len = PW'(11);
    cur.g_len[0*PW +: PW]   = PW'(3);
    cur.g_start[0*PW +: PW] = PW'(2);
    cur.g_len[1*PW +: PW]   = PW'(2);
    cur.g_start[1*PW +: PW] = PW'(9);
    for (int j = 0; j < NV; j++) begin
      cur.g_pol[j]                   = 1'(j % 2);
      cur.g_t1[j*PW +: PW]           = PW'(1);
      cur.g_t2[j*PW +: PW]           = PW'(3);
      cur.g_pol[NV + j]              = 1'b0;
      cur.g_t1[(NV + j)*PW +: PW]    = PW'(0);
      cur.g_t2[(NV + j)*PW +: PW]    = PW'(2);
    end
    cur.sel      = 13'h0AAA;
    cur.rep_odd  = RW'(3);
    cur.rep_even = RW'(1);
    cur.s_pol    = 3'b010;
    cur.s_t1     = {PW'(20), PW'(5), PW'(1)};
    cur.s_t2     = {PW'(25), PW'(15), PW'(4)};
  endtask

  function automatic logic [2:0] stb_model(int p);
    logic [2:0] r;
    for (int s = 0; s < 3; s++)
      r[s] = snap.s_pol[s] ^ (p >= int'(snap.s_t1[s*PW +: PW]))
                           ^ (p >= int'(snap.s_t2[s*PW +: PW]));
    return r;
  endfunction

  task automatic vclk_step(int p, bit odd);
    int rep;
    rep = odd ? int'(snap.rep_odd) : int'(snap.rep_even);
    for (int j = 0; j < NV; j++) begin
      int g, len, st, q;
      logic lvl, hold;
      g   = int'(snap.sel[j]);
      len = int'(snap.g_len[g*PW +: PW]) + 1;
      st  = int'(snap.g_start[g*PW +: PW]);
      lvl = snap.g_pol[g*NV + j];
      if (p >= st && p < st + len*(rep + 1)) begin
        q   = (p - st) % len;
        lvl = lvl ^ (q >= int'(snap.g_t1[(g*NV + j)*PW +: PW]))
                  ^ (q >= int'(snap.g_t2[(g*NV + j)*PW +: PW]));
      end
      hold = 1'b0;
      for (int k = 0; k < 2; k++)
        if (snap.f_en[k] && p >= int'(snap.f_pos[k*PW +: PW])
            && p < int'(snap.r_pos[k*PW +: PW]))
          hold = 1'b1;
      if (!(hold && snap.mask[j])) exp_v[j] = lvl;
    end
  endtask

  // One line: snapshot, strobe, scramble config mid-line (R9), check every pixel.
  task automatic run_line(bit odd, bit last);
    int n;
    snap = cur;
    line_odd  = odd;
    last_line = last;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    rand_cfg();
    line_odd  = ~odd;
    last_line = ~last;
    n = (last ? int'(snap.last_len) : int'(snap.line_len)) + 1;
    for (int p = 0; p < n + 3; p++) begin
      int pp;
      @(negedge clk);
      pp = (p < n) ? p : n - 1;
      if (p < n) vclk_step(p, odd);
      chk("R4 R5 R6 R7 R9 vclk", 32'(vclk), 32'(exp_v));
      chk("R1 R2 R3 hd", 32'(hd), 32'(p == 0));
      chk("R8 R9 strobes", 32'({hblk, pblk, clamp}), 32'(stb_model(pp)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cur = '0;
    exp_v = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 vclk", 32'(vclk), 32'd0);
    chk("R10 hd", 32'(hd), 32'd0);
    chk("R10 strobes", 32'({hblk, pblk, clamp}), 32'd0);

    // R6 even line, then odd line with more repeats
    base_cfg(); run_line(1'b0, 1'b0);
    base_cfg(); run_line(1'b1, 1'b0);
    // R3 last line uses the short length
    base_cfg(); run_line(1'b0, 1'b1);
    // R7 both hold windows on, mask half the outputs
    base_cfg();
    cur.f_en  = 2'b11;
    cur.mask  = 13'h0F0F;
    cur.f_pos = {PW'(17), PW'(4)};
    cur.r_pos = {PW'(22), PW'(8)};
    run_line(1'b1, 1'b0);
    // R7 disabled windows do nothing
    base_cfg();
    cur.f_en  = 2'b00;
    cur.mask  = 13'h1FFF;
    cur.f_pos = {PW'(0), PW'(0)};
    cur.r_pos = {PW'(29), PW'(29)};
    run_line(1'b0, 1'b0);
    // R6 group start beyond the line never runs
    base_cfg();
    cur.g_start = {PW'(40), PW'(35)};
    run_line(1'b1, 1'b0);
    // R1 single-pixel line
    base_cfg();
    cur.line_len = PW'(0);
    run_line(1'b0, 1'b0);

    for (int i = 0; i < 60; i++) begin
      rand_cfg();
      repeat ($urandom_range(2, 0)) @(negedge clk);
      run_line(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule